// File: doc/BRIEF.md
# Alarm-Driven Power Enable Controller

This block sits beside a real-time clock and owns the enable pin of an external power-management device. Software loads a second, full-date shutdown alarm (seconds, minutes, hours, day, month, year, all BCD) and sets a control bit that hands the enable pin to this logic. When the running clock time equals every field of that alarm, the enable pin drops to its off level and the system powers down at the programmed instant. Software must arm the alarm at least two seconds ahead, because the compare fields have to be written before the next one-second update of the clock.

While power is off, any of four external wake pins can restore it. Each pin has its own enable bit and polarity bit in one packed power-control word. Each pin passes through a two-flop synchronizer before its polarity and enable are applied. An alarm status flag and a wake status flag are both write-one-to-clear. The alarm flag also drives an interrupt through its own enable bit. The register port is a plain single-cycle write strobe. The clock time arrives as a parallel BCD vector from the time counter, which lies outside this block.

Top module: `pwr_alarm_ctl`

## Requirements
- R1: After reset, `pwr_en` is 1, both status flags and `irq_alarm2` are 0, all wake enables are 0, and all wake polarity bits are 1.
- R2: Shutdown alarm fields are written from `cfg_wdata[7:0]` at byte addresses 0x80 (seconds), 0x84 (minutes), 0x88 (hours), 0x8C (day), 0x90 (month) and 0x94 (year). `now_time` packs seconds in [7:0] up to year in [47:40]. When all six fields become equal and bit 16 of the power-control word at 0x98 is 1, `pwr_en` goes to 0 on the second rising edge after the match appears.
- R3: A time that differs from the alarm in any single field leaves `pwr_en` and the alarm flag unchanged.
- R4: With power-control bit 16 at 0, `pwr_en` is 1 one cycle later and remains 1 even when the alarm matches, while the alarm flag still sets.
- R5: A match sets the alarm flag (`alarm2_flag`, status bit 7 at address 0x44). Writing 1 to bit 7 at 0x44 clears it, writing 0 leaves it set, and a set in the same cycle wins over a clear.
- R6: `irq_alarm2` is 1 exactly when the alarm flag is 1 and bit 4 of the interrupt-enable word at 0x48 is 1.
- R7: Bits 3:0 of the power-control word enable wake pins 3:0. Bits 7:4 give their polarity, where 1 means active low and 0 means active high. While `pwr_en` is 0, an enabled pin held at its active level sets `pwr_en` to 1 and sets `wake_flag` (status bit 1 at 0x44, write-one-to-clear) on the third rising edge after the pin changes.
- R8: A wake pin whose enable bit is 0 has no effect on `pwr_en` or `wake_flag`.
- R9: While `pwr_en` is 1, an enabled, active wake pin leaves `wake_flag` at 0.
- R10: The alarm fires only on the transition into a match. A time that stays equal to the alarm does not set the flag again after it has been cleared. A match that is already present when reset releases does not fire.
- R11: Clearing bit 16 while power is off restores `pwr_en` to 1 one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| now_time | input | 48 | Current BCD time, seconds in the low byte, year in the high byte |
| wake_pin | input | 4 | Asynchronous external wake inputs |
| pwr_en | output | 1 | Power enable to the external power device, 1 = on |
| alarm2_flag | output | 1 | Shutdown alarm status flag |
| wake_flag | output | 1 | Wake status flag |
| irq_alarm2 | output | 1 | Shutdown alarm interrupt |

## Verification
The bound checker checks four things on every cycle:
- A falling `pwr_en` always follows an alarm hit taken while power control was on.
- With power control off, `pwr_en` is high on the next cycle.
- A rising alarm flag always follows a hit.
- A new wake flag always arrives together with power returning, and the interrupt never rises without the flag.

The directed scenarios are needed for the rest:
- The exact latency of the alarm path and of the synchronized wake path.
- That a mismatch in seconds or in year blocks the alarm, and that the alarm fires once per match.
- That polarity is applied both ways, and that disabled pins, or any pin while power is on, have no effect.
- How the write-one-to-clear status bits behave.

// File: rtl/pac_pkg.sv
package pac_pkg;
  localparam int FIELD_W  = 8;
  localparam int N_FIELDS = 6;
  localparam int N_WAKE   = 4;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int TIME_W   = FIELD_W * N_FIELDS;

  localparam logic [ADDR_W-1:0] A_STATUS   = 8'h44;
  localparam logic [ADDR_W-1:0] A_INTEN    = 8'h48;
  localparam logic [ADDR_W-1:0] A_ALM_BASE = 8'h80;
  localparam logic [ADDR_W-1:0] A_PWRCTL   = 8'h98;

  localparam int ST_ALARM_BIT = 7;
  localparam int ST_WAKE_BIT  = 1;
  localparam int IE_ALARM_BIT = 4;
  localparam int PC_CTL_BIT   = 16;
endpackage

// File: rtl/pac_regs.sv
module pac_regs
  import pac_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                set_alarm,
  input  logic                set_wake,
  output logic [TIME_W-1:0]   alarm_time,
  output logic                ctl_on,
  output logic [N_WAKE-1:0]   wake_en,
  output logic [N_WAKE-1:0]   wake_pol,
  output logic                ie_alarm,
  output logic                st_alarm,
  output logic                st_wake
);
  logic unused_wdata_bits;
  assign unused_wdata_bits = ^{wdata[DATA_W-1:PC_CTL_BIT+1], wdata[PC_CTL_BIT-1:2*N_WAKE]};

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
    localparam logic [ADDR_W-1:0] FADDR = ADDR_W'(A_ALM_BASE + 4 * i);
    always_ff @(posedge clk) begin
      if (!rst_n)                    alarm_time[i*FIELD_W +: FIELD_W] <= '0;
      else if (we && addr == FADDR)  alarm_time[i*FIELD_W +: FIELD_W] <= wdata[FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_on   <= 1'b0;
      wake_en  <= '0;
      wake_pol <= '1;
      ie_alarm <= 1'b0;
    end else if (we) begin
      if (addr == A_PWRCTL) begin
        ctl_on   <= wdata[PC_CTL_BIT];
        wake_en  <= wdata[N_WAKE-1:0];
        wake_pol <= wdata[2*N_WAKE-1:N_WAKE];
      end
      if (addr == A_INTEN) ie_alarm <= wdata[IE_ALARM_BIT];
    end
  end

  logic clr_alarm, clr_wake;
  assign clr_alarm = we && addr == A_STATUS && wdata[ST_ALARM_BIT];
  assign clr_wake  = we && addr == A_STATUS && wdata[ST_WAKE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_alarm <= 1'b0;
      st_wake  <= 1'b0;
    end else begin
      if (set_alarm)      st_alarm <= 1'b1;
      else if (clr_alarm) st_alarm <= 1'b0;
      if (set_wake)       st_wake  <= 1'b1;
      else if (clr_wake)  st_wake  <= 1'b0;
    end
  end
endmodule

// File: rtl/pac_alarm_cmp.sv
module pac_alarm_cmp
  import pac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_time,
  input  logic [TIME_W-1:0] alarm_time,
  output logic              hit
);
  logic [N_FIELDS-1:0] field_eq;
  logic match, match_q;

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_eq
    assign field_eq[i] = now_time[i*FIELD_W +: FIELD_W] == alarm_time[i*FIELD_W +: FIELD_W];
  end
  assign match = &field_eq;

  // match_q resets to 1 so a match already present at reset release is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= 1'b1;
      hit     <= 1'b0;
    end else begin
      match_q <= match;
      hit     <= match && !match_q;
    end
  end
endmodule

// File: rtl/pac_wake.sv
module pac_wake
  import pac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_WAKE-1:0] pin,
  input  logic [N_WAKE-1:0] en,
  input  logic [N_WAKE-1:0] pol,
  output logic              any_wake
);
  logic [N_WAKE-1:0] active;

  for (genvar i = 0; i < N_WAKE; i++) begin : g_pin
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= pin[i];
        s2 <= s1;
      end
    end
    // pol = 1: low level is active
    assign active[i] = en[i] && (s2 ^ pol[i]);
  end
  assign any_wake = |active;
endmodule

// File: rtl/pwr_alarm_ctl.sv
module pwr_alarm_ctl
  import pac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic [47:0] now_time,
  input  logic [3:0]  wake_pin,
  output logic        pwr_en,
  output logic        alarm2_flag,
  output logic        wake_flag,
  output logic        irq_alarm2
);
  logic [TIME_W-1:0] alarm_time;
  logic [N_WAKE-1:0] wake_en, wake_pol;
  logic pwr_ctl_on, ie_alarm, alarm_hit, any_wake, off_q, set_wake;

  assign set_wake = pwr_ctl_on && off_q && any_wake;

  pac_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .set_alarm(alarm_hit), .set_wake(set_wake), .alarm_time(alarm_time),
    .ctl_on(pwr_ctl_on), .wake_en(wake_en), .wake_pol(wake_pol),
    .ie_alarm(ie_alarm), .st_alarm(alarm2_flag), .st_wake(wake_flag)
  );

  pac_alarm_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .now_time(now_time), .alarm_time(alarm_time), .hit(alarm_hit)
  );

  pac_wake u_wake (
    .clk(clk), .rst_n(rst_n), .pin(wake_pin), .en(wake_en), .pol(wake_pol), .any_wake(any_wake)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                  off_q <= 1'b0;
    else if (!pwr_ctl_on)        off_q <= 1'b0;
    else if (!off_q && alarm_hit) off_q <= 1'b1;
    else if (off_q && any_wake)  off_q <= 1'b0;
  end

  assign pwr_en     = !off_q;
  assign irq_alarm2 = alarm2_flag && ie_alarm;
endmodule

// File: rtl/pac_chk.sv
module pac_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_en,
  input logic alarm2_flag,
  input logic wake_flag,
  input logic irq_alarm2,
  input logic alarm_hit,
  input logic pwr_ctl_on
);
  // R2
  pwr_off_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> ($past(alarm_hit) && $past(pwr_ctl_on)));
  // R4
  ctl_off_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ctl_on |=> pwr_en);
  // R5
  alarm_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm2_flag) |-> $past(alarm_hit));
  // R7
  wake_with_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $rose(pwr_en));
  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_alarm2 |-> alarm2_flag);
endmodule

bind pwr_alarm_ctl pac_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .alarm2_flag(alarm2_flag),
  .wake_flag(wake_flag), .irq_alarm2(irq_alarm2), .alarm_hit(alarm_hit),
  .pwr_ctl_on(pwr_ctl_on)
);

// File: tb/pwr_alarm_ctl_tb_top.sv
module pwr_alarm_ctl_tb_top;
  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [7:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [47:0] now_time;
  logic [3:0] wake_pin = 4'hF;
  logic pwr_en, alarm2_flag, wake_flag, irq_alarm2;
  int checks = 0, errors = 0;

  localparam logic [47:0] T_MATCH = {8'h25, 8'h12, 8'h31, 8'h23, 8'h59, 8'h58};
  localparam logic [47:0] T_SEC   = {8'h25, 8'h12, 8'h31, 8'h23, 8'h59, 8'h57};
  localparam logic [47:0] T_YEAR  = {8'h26, 8'h12, 8'h31, 8'h23, 8'h59, 8'h58};

  always #4 clk = ~clk;

  pwr_alarm_ctl dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic fire_alarm();
    now_time = T_SEC; cyc(2);
    now_time = T_MATCH; cyc(2);
  endtask

  task automatic t_reset();
    check("R1 pwr_en", pwr_en, 1);
    check("R1 alarm2_flag", alarm2_flag, 0);
    check("R1 wake_flag", wake_flag, 0);
    check("R1 irq", irq_alarm2, 0);
  endtask

  task automatic t_partial();
    wr(8'h80, 32'h58); wr(8'h84, 32'h59); wr(8'h88, 32'h23);
    wr(8'h8C, 32'h31); wr(8'h90, 32'h12); wr(8'h94, 32'h25);
    wr(8'h98, 32'h0001_00F0);
    cyc(3);
    check("R3 seconds differ pwr_en", pwr_en, 1);
    check("R3 seconds differ flag", alarm2_flag, 0);
    now_time = T_YEAR; cyc(3);
    check("R3 year differs pwr_en", pwr_en, 1);
    check("R3 year differs flag", alarm2_flag, 0);
  endtask

  task automatic t_alarm();
    wr(8'h48, 32'h10);
    now_time = T_MATCH; cyc(1);
    check("R2 one edge after match", pwr_en, 1);
    cyc(1);
    check("R2 pwr_en off", pwr_en, 0);
    check("R5 flag set", alarm2_flag, 1);
    check("R6 irq with enable", irq_alarm2, 1);
    wr(8'h48, 32'h0);
    check("R6 irq masked", irq_alarm2, 0);
    wr(8'h44, 32'h0);
    check("R5 write zero keeps flag", alarm2_flag, 1);
    wr(8'h44, 32'h80);
    check("R5 w1c clears", alarm2_flag, 0);
    cyc(4);
    check("R10 held match no refire", alarm2_flag, 0);
  endtask

  task automatic t_wake_disabled();
    wake_pin[0] = 0; cyc(5);
    check("R8 disabled pin pwr_en", pwr_en, 0);
    check("R8 disabled pin flag", wake_flag, 0);
    wake_pin[0] = 1; cyc(3);
  endtask

  task automatic t_wake_low();
    wr(8'h98, 32'h0001_00F1);
    cyc(2);
    check("R7 idle high no wake", pwr_en, 0);
    wake_pin[0] = 0; cyc(2);
    check("R7 not before sync", pwr_en, 0);
    cyc(1);
    check("R7 active low wake pwr_en", pwr_en, 1);
    check("R7 wake flag", wake_flag, 1);
    wr(8'h44, 32'h2);
    check("R7 wake flag w1c", wake_flag, 0);
    wake_pin[0] = 1; cyc(3);
  endtask

  task automatic t_wake_high();
    wake_pin[2] = 0;
    fire_alarm();
    check("R2 second shutdown", pwr_en, 0);
    wr(8'h44, 32'h80);
    wr(8'h98, 32'h0001_00B4);
    cyc(4);
    check("R7 active high idle low", pwr_en, 0);
    wake_pin[2] = 1; cyc(3);
    check("R7 active high wake", pwr_en, 1);
    check("R7 active high flag", wake_flag, 1);
    wr(8'h44, 32'h2);
  endtask

  task automatic t_wake_on();
    wake_pin[2] = 0; cyc(3);
    wake_pin[2] = 1; cyc(4);
    check("R9 wake while on flag", wake_flag, 0);
    check("R9 wake while on pwr_en", pwr_en, 1);
    wake_pin[2] = 0; cyc(3);
  endtask

  task automatic t_ctl_clear();
    fire_alarm();
    check("R11 off before clear", pwr_en, 0);
    wr(8'h44, 32'h80);
    wr(8'h98, 32'h0000_00F0);
    check("R11 not yet restored", pwr_en, 0);
    cyc(1);
    check("R11 restored", pwr_en, 1);
    fire_alarm();
    check("R4 stays on", pwr_en, 1);
    check("R4 flag still sets", alarm2_flag, 1);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    now_time = T_SEC;
    cyc(5);
    rst_n = 1;
    cyc(1);
    t_reset();
    t_partial();
    t_alarm();
    t_wake_disabled();
    t_wake_low();
    t_wake_high();
    t_wake_on();
    t_ctl_clear();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule